// File: doc/BRIEF.md
# Host-to-PCI Bridge Control Register and Soft-Reset Sequencer

This block holds the control word of a host-bus-to-PCI bridge and runs the selective software reset of the PCI side. Software reaches it through a simple register port. The port serves two local words, the control word and a sticky error-status word. Every other address passes straight through to the rest of the bridge's register file. The control word carries four initiator address-space enables, an enable for bus-error signalling on failed initiator reads, and a soft-reset bit.

Setting the soft-reset bit raises a reset and a configuration-reload request toward the PCI-side logic. That request is held for at least a minimum number of PCI clock ticks, whenever software clears the bit. While soft reset is in force, the block refuses every register access except to the control word itself. It keeps the error-status word and its own reset bit, and it returns the other control fields to their defaults. The block also classifies each initiator read completion as good, as a bus error, or as a normal completion with invalid data, from five error flags and the bus-error enable.

Top module: `pcib_ctl`

## Requirements
- R1: Hardware reset sets the control word to: soft reset 0, bus-error enable 1, memory spaces 0 and 1 off, I/O space off, and memory space 2 equal to `boot_strap` sampled during reset. It also clears the status word and drives `pci_srst` and `cfg_reload` low.
- R2: The control word sits at address 0. Its fields are at bit 10 memory space 0, bit 9 memory space 1, bit 8 memory space 2, bit 7 I/O space, bit 6 bus-error enable and bit 5 soft reset. All six are read/write, and every other bit reads 0.
- R3: Writing 1 to bit 5 sets soft reset only if `eeprom_done` is 1 in that cycle. If `eeprom_done` is 0, the write of that bit has no effect. Once set, the bit stays 1 until software writes 0. `pci_srst` is high from the cycle after the setting write, and `cfg_reload` is high from the cycle after that.
- R4: `pci_srst` and `cfg_reload` drop only after the bit is clear and at least MIN_TICKS (default 4) `pci_tick` pulses have been counted since the sequence started. If the count is already complete, both drop one cycle after the clearing write.
- R5: While `pci_srst` is high, any access to an address other than 0 is refused. A refused read returns 0, a refused write is discarded, and `fwd_req` stays low.
- R6: While `pci_srst` is high, the control word stays accessible. Writes to it change only bit 5. From the second cycle of soft reset onward, the other fields hold their hardware-reset defaults.
- R7: The status word sits at address 1. Bits 4..0 are, in order, parity error, master abort, target abort, TRDY timeout and retry timeout. A bit is set when a read completes with that flag, and writing 1 to a bit clears it. Soft reset leaves the word unchanged.
- R8: One cycle after `rd_done`, `rd_cpl` pulses. `rd_buserr` pulses with it when any `rd_flags` bit was set and the bus-error enable is 1.
- R9: When a flag was set and the bus-error enable is 0, `rd_dinv` pulses instead and `rd_buserr` stays low.
- R10: A completion with no flag set raises neither `rd_buserr` nor `rd_dinv`.
- R11: Every access is acknowledged by `reg_ack` one cycle after `reg_req`. A read returns its data in that same cycle. Outside soft reset, addresses 2 and above drive `fwd_req` in the request cycle and return `fwd_rdata`.
- R12: `mem_en[2:0]` and `io_en` always equal control bits 8..10 (memory space 2..0) and bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| boot_strap | input | 1 | PCI boot strap, sampled during reset |
| eeprom_done | input | 1 | Configuration EEPROM load complete |
| pci_tick | input | 1 | One pulse per PCI clock cycle |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_ack | output | 1 | Access acknowledge |
| reg_rdata | output | DATA_W | Read data |
| fwd_req | output | 1 | Forwarded access request |
| fwd_we | output | 1 | Forwarded write enable |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_rdata | input | DATA_W | Read data of the forwarded register file |
| rd_done | input | 1 | Initiator read finished on PCI |
| rd_flags | input | 5 | Error flags of that read (bit order as R7) |
| rd_cpl | output | 1 | Host completion pulse |
| rd_buserr | output | 1 | Completion carries a bus error |
| rd_dinv | output | 1 | Normal completion with invalid data |
| mem_en | output | 3 | Memory space 2..0 enables |
| io_en | output | 1 | I/O space enable |
| pci_srst | output | 1 | Reset toward PCI-side logic |
| cfg_reload | output | 1 | Configuration reload request |

## Verification
The assertions take for granted that `pci_tick` pulses last a single cycle and that `reg_req` is never held over two cycles. They also take for granted that `rd_flags` carries meaning only in a cycle with `rd_done`. The stimulus drives every request, tick and completion as an isolated one-cycle pulse on the falling clock edge and returns the flags to zero afterwards. Soft reset is entered both with and without `eeprom_done`, and it is cleared both before and after the tick count completes, so that both release paths of the sequencer occur.

// File: rtl/pcib_ctl_pkg.sv
// Shared constants and field type of the bridge control block.
// Assumes: the control word fits in any DATA_W of 11 bits or more.
package pcib_ctl_pkg;
    localparam int BIT_MEM0  = 10;
    localparam int BIT_MEM1  = 9;
    localparam int BIT_MEM2  = 8;
    localparam int BIT_IO    = 7;
    localparam int BIT_RBERR = 6;
    localparam int BIT_SRST  = 5;
    localparam int NUM_ERR   = 5;

    // Control fields other than the soft-reset bit
    typedef struct packed {
        logic mem0;
        logic mem1;
        logic mem2;
        logic io;
        logic rberr;
    } ctl_fields_t;
endpackage

// File: rtl/pcib_srst_seq.sv
// Soft-reset sequencer: starts when the soft-reset bit is seen, counts PCI
// ticks, and keeps the sequence active until the bit is clear and the
// minimum tick count is reached.
// Assumes: pci_tick is a single-cycle pulse in the clk domain.
module pcib_srst_seq #(
    parameter int MIN_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pci_tick,
    input  logic srst_bit,
    output logic active
);
    localparam int CNT_W = $clog2(MIN_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_TICKS);

    logic [CNT_W-1:0] tick_cnt;
    logic             cnt_done;

    assign cnt_done = (tick_cnt >= CNT_MAX);

    // Sequence state: start on the bit, count ticks, release when both allow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            tick_cnt <= '0;
        end else if (!active) begin
            if (srst_bit) begin
                active   <= 1'b1;
                tick_cnt <= '0;
            end
        end else begin
            if (pci_tick && !cnt_done) begin
                tick_cnt <= tick_cnt + 1'b1;
            end
            if (!srst_bit && cnt_done) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcib_rd_resp.sv
// Initiator read response: classifies each finished read as good, bus
// error or normal completion with invalid data, registered one cycle.
// Assumes: rd_flags is only meaningful while rd_done is high.
module pcib_rd_resp
    import pcib_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_done,
    input  logic [NUM_ERR-1:0] rd_flags,
    input  logic               buserr_en,
    output logic               rd_cpl,
    output logic               rd_buserr,
    output logic               rd_dinv,
    output logic [NUM_ERR-1:0] err_set
);
    logic failed;

    assign failed  = |rd_flags;
    assign err_set = rd_done ? rd_flags : '0;

    // Completion outputs, one cycle after the read finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cpl    <= 1'b0;
            rd_buserr <= 1'b0;
            rd_dinv   <= 1'b0;
        end else begin
            rd_cpl    <= rd_done;
            rd_buserr <= rd_done && failed && buserr_en;
            rd_dinv   <= rd_done && failed && !buserr_en;
        end
    end
endmodule

// File: rtl/pcib_ctl_regs.sv
// Register port: control word, sticky error-status word and pass-through
// to the remaining register file, with refusal while soft reset is in force.
// Assumes: fwd_rdata is valid combinationally in the request cycle.
module pcib_ctl_regs
    import pcib_ctl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_strap,
    input  logic               eeprom_done,
    input  logic               blocked,
    input  logic               reg_req,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic               reg_ack,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               fwd_req,
    output logic               fwd_we,
    output logic [ADDR_W-1:0]  fwd_addr,
    output logic [DATA_W-1:0]  fwd_wdata,
    input  logic [DATA_W-1:0]  fwd_rdata,
    input  logic [NUM_ERR-1:0] err_set,
    output ctl_fields_t        fields,
    output logic               srst_bit
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic               boot_q;
    logic [NUM_ERR-1:0] status;
    logic               hit_ctrl;
    logic               hit_stat;
    logic               wr_ctrl;
    logic               wr_stat;
    logic [DATA_W-1:0]  ctrl_word;
    logic [DATA_W-1:0]  rd_val;
    logic [NUM_ERR-1:0] clr_mask;
    ctl_fields_t        dflt;

    assign hit_ctrl = (reg_addr == A_CTRL);
    assign hit_stat = (reg_addr == A_STAT);
    assign wr_ctrl  = reg_req && reg_we && hit_ctrl;
    assign wr_stat  = reg_req && reg_we && hit_stat && !blocked;
    assign clr_mask = wr_stat ? reg_wdata[NUM_ERR-1:0] : '0;

    // Defaults that soft reset returns the fields to
    always_comb begin
        dflt       = '0;
        dflt.mem2  = boot_q;
        dflt.rberr = 1'b1;
    end

    // Control word image for reads
    always_comb begin
        ctrl_word            = '0;
        ctrl_word[BIT_MEM0]  = fields.mem0;
        ctrl_word[BIT_MEM1]  = fields.mem1;
        ctrl_word[BIT_MEM2]  = fields.mem2;
        ctrl_word[BIT_IO]    = fields.io;
        ctrl_word[BIT_RBERR] = fields.rberr;
        ctrl_word[BIT_SRST]  = srst_bit;
    end

    // Read source selection with refusal of non-control words
    always_comb begin
        if (hit_ctrl)      rd_val = ctrl_word;
        else if (blocked)  rd_val = '0;
        else if (hit_stat) rd_val = DATA_W'(status);
        else               rd_val = fwd_rdata;
    end

    assign fwd_req   = reg_req && !blocked && !hit_ctrl && !hit_stat;
    assign fwd_we    = reg_we;
    assign fwd_addr  = reg_addr;
    assign fwd_wdata = reg_wdata;

    // Control fields, soft-reset bit and latched boot strap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q   <= boot_strap;
            fields   <= '{mem0: 1'b0, mem1: 1'b0, mem2: boot_strap,
                          io: 1'b0, rberr: 1'b1};
            srst_bit <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                srst_bit <= reg_wdata[BIT_SRST] && (srst_bit || eeprom_done);
            end
            if (blocked) begin
                fields <= dflt;
            end else if (wr_ctrl) begin
                fields.mem0  <= reg_wdata[BIT_MEM0];
                fields.mem1  <= reg_wdata[BIT_MEM1];
                fields.mem2  <= reg_wdata[BIT_MEM2];
                fields.io    <= reg_wdata[BIT_IO];
                fields.rberr <= reg_wdata[BIT_RBERR];
            end
        end
    end

    // Sticky error status: set by completions, cleared by writing ones
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | err_set;
    end

    // Access acknowledge and registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_ack   <= reg_req;
            reg_rdata <= (reg_req && !reg_we) ? rd_val : '0;
        end
    end
endmodule

// File: rtl/pcib_ctl.sv
// Bridge control top: register port, soft-reset sequencer and initiator
// read response. Drives space enables and the PCI-side reset/reload.
// Assumes: DATA_W >= 11 so the control word fits.
module pcib_ctl
    import pcib_ctl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int MIN_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_strap,
    input  logic               eeprom_done,
    input  logic               pci_tick,
    input  logic               reg_req,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic               reg_ack,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               fwd_req,
    output logic               fwd_we,
    output logic [ADDR_W-1:0]  fwd_addr,
    output logic [DATA_W-1:0]  fwd_wdata,
    input  logic [DATA_W-1:0]  fwd_rdata,
    input  logic               rd_done,
    input  logic [NUM_ERR-1:0] rd_flags,
    output logic               rd_cpl,
    output logic               rd_buserr,
    output logic               rd_dinv,
    output logic [2:0]         mem_en,
    output logic               io_en,
    output logic               pci_srst,
    output logic               cfg_reload
);
    ctl_fields_t        fields;
    logic               srst_bit;
    logic               seq_active;
    logic               blocked;
    logic [NUM_ERR-1:0] err_set;

    assign blocked    = srst_bit || seq_active;
    assign pci_srst   = blocked;
    assign cfg_reload = seq_active;
    assign mem_en     = {fields.mem2, fields.mem1, fields.mem0};
    assign io_en      = fields.io;

    pcib_ctl_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_ADDR(0),
        .STAT_ADDR(1)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_strap (boot_strap),
        .eeprom_done(eeprom_done),
        .blocked    (blocked),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_ack    (reg_ack),
        .reg_rdata  (reg_rdata),
        .fwd_req    (fwd_req),
        .fwd_we     (fwd_we),
        .fwd_addr   (fwd_addr),
        .fwd_wdata  (fwd_wdata),
        .fwd_rdata  (fwd_rdata),
        .err_set    (err_set),
        .fields     (fields),
        .srst_bit   (srst_bit)
    );

    pcib_srst_seq #(
        .MIN_TICKS(MIN_TICKS)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pci_tick(pci_tick),
        .srst_bit(srst_bit),
        .active  (seq_active)
    );

    pcib_rd_resp resp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_done  (rd_done),
        .rd_flags (rd_flags),
        .buserr_en(fields.rberr),
        .rd_cpl   (rd_cpl),
        .rd_buserr(rd_buserr),
        .rd_dinv  (rd_dinv),
        .err_set  (err_set)
    );
endmodule

// File: rtl/pcib_ctl_chk.sv
// Property checker for pcib_ctl, attached with bind below.
// Assumes: single-cycle pci_tick and reg_req pulses.
module pcib_ctl_chk
    import pcib_ctl_pkg::*;
#(
    parameter int MIN_TICKS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               eeprom_done,
    input logic               pci_tick,
    input logic               reg_req,
    input logic               reg_ack,
    input logic               fwd_req,
    input logic               rd_done,
    input logic [NUM_ERR-1:0] rd_flags,
    input logic               rd_cpl,
    input logic               rd_buserr,
    input logic               rd_dinv,
    input logic [2:0]         mem_en,
    input logic               io_en,
    input logic               pci_srst,
    input logic               cfg_reload
);
    localparam int CW = $clog2(MIN_TICKS + 1);

    logic [CW-1:0] seen_ticks;

    // Ticks observed while the PCI-side reset is high (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n || !pci_srst)                         seen_ticks <= '0;
        else if (pci_tick && seen_ticks < CW'(MIN_TICKS)) seen_ticks <= seen_ticks + 1'b1;
    end

    assert_set_needs_eeprom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_srst) |-> $past(eeprom_done));

    assert_reload_within_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reload |-> pci_srst);

    assert_min_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_srst) |-> (seen_ticks >= CW'(MIN_TICKS)));

    assert_no_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pci_srst |-> !fwd_req);

    assert_spaces_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_srst && $past(pci_srst)) |-> (!mem_en[0] && !mem_en[1] && !io_en));

    assert_buserr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_buserr |-> ($past(rd_done) && ($past(rd_flags) != '0) && rd_cpl));

    assert_outcome_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_buserr && rd_dinv));

    assert_clean_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_flags == '0) |=> (rd_cpl && !rd_buserr && !rd_dinv));

    assert_ack_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> reg_ack);
endmodule

bind pcib_ctl pcib_ctl_chk #(.MIN_TICKS(MIN_TICKS)) chk_i (.*);

// File: tb/pcib_ctl_tb_top.sv
// Self-checking bench for pcib_ctl: seeded random and directed stimulus.
module pcib_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          boot_strap;
    logic          eeprom_done;
    logic          pci_tick;
    logic          reg_req;
    logic          reg_we;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_ack;
    logic [DW-1:0] reg_rdata;
    logic          fwd_req;
    logic          fwd_we;
    logic [AW-1:0] fwd_addr;
    logic [DW-1:0] fwd_wdata;
    logic [DW-1:0] fwd_rdata;
    logic          rd_done;
    logic [4:0]    rd_flags;
    logic          rd_cpl;
    logic          rd_buserr;
    logic          rd_dinv;
    logic [2:0]    mem_en;
    logic          io_en;
    logic          pci_srst;
    logic          cfg_reload;

    int n_chk  = 0;
    int n_fail = 0;
    logic [4:0]  stat_m;
    logic [31:0] ctrl_m;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fwd_rdata = {24'hC3A55A, 4'h0, fwd_addr};

    pcib_ctl dut_i (.*);

    function automatic logic [31:0] fwd_pattern(input logic [AW-1:0] a);
        return {24'hC3A55A, 4'h0, a};
    endfunction

    function automatic logic [2:0] exp_resp(input logic en, input logic [4:0] f);
        // {cpl, buserr, dinv}
        return {1'b1, (f != 0) && en, (f != 0) && !en};
    endfunction

    function automatic logic [31:0] dflt_ctrl(input logic strap);
        return {21'b0, 1'b0, 1'b0, strap, 1'b0, 1'b1, 6'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic fseen);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        #1 fseen = fwd_req;
        @(posedge clk);
        #1;
        rd = reg_rdata;
        chk("R11 ack", {31'b0, reg_ack}, 32'd1);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); pci_tick = 1'b1;
        @(negedge clk); pci_tick = 1'b0;
    endtask

    task automatic rd_cycle(input logic [4:0] f, output logic [2:0] got);
        @(negedge clk); rd_done = 1'b1; rd_flags = f;
        @(posedge clk); #1;
        got = {rd_cpl, rd_buserr, rd_dinv};
        rd_done = 1'b0; rd_flags = '0;
    endtask

    task automatic hw_reset(input logic strap);
        @(negedge clk); rst_n = 1'b0; boot_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        stat_m = '0;
        ctrl_m = dflt_ctrl(strap);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        fs;
        logic [2:0]  got;
        void'($urandom(32'd1309));
        rst_n = 1'b0; boot_strap = 1'b1; eeprom_done = 1'b0; pci_tick = 1'b0;
        reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        rd_done = 1'b0; rd_flags = '0;
        hw_reset(1'b1);

        // R1: reset state with PCI boot strap
        #1;
        chk("R1 pci_srst", {31'b0, pci_srst}, 32'd0);
        chk("R1 cfg_reload", {31'b0, cfg_reload}, 32'd0);
        chk("R12 mem_en after reset", {29'b0, mem_en}, 32'd4);
        host(1'b0, 4'd0, '0, rd, fs);
        chk("R1 ctrl default", rd, dflt_ctrl(1'b1));
        host(1'b0, 4'd1, '0, rd, fs);
        chk("R1 status clear", rd, 32'd0);

        // R2/R12: random control writes with soft reset bit clear
        for (int i = 0; i < 20; i++) begin
            logic [31:0] d;
            d = $urandom() & ~32'h20;
            host(1'b1, 4'd0, d, rd, fs);
            ctrl_m = d & 32'h7C0;
            host(1'b0, 4'd0, '0, rd, fs);
            chk("R2 ctrl readback", rd, ctrl_m);
            chk("R12 space enables", {28'b0, mem_en, io_en},
                {28'b0, ctrl_m[8], ctrl_m[9], ctrl_m[10], ctrl_m[7]});
        end

        // R11: forwarded reads and writes
        for (int i = 0; i < 10; i++) begin
            logic [AW-1:0] a;
            a = AW'(2 + ($urandom() % 14));
            host(1'b0, a, '0, rd, fs);
            chk("R11 forward read", rd, fwd_pattern(a));
            host(1'b1, a, $urandom(), rd, fs);
            chk("R11 forward req", {31'b0, fs}, 32'd1);
        end

        // R8/R9/R10/R7: random read completions under both enable settings
        for (int i = 0; i < 40; i++) begin
            logic [4:0] f;
            if (i % 8 == 0) begin
                ctrl_m = ($urandom() & 32'h7C0);
                host(1'b1, 4'd0, ctrl_m, rd, fs);
            end
            f = ($urandom() % 2 == 0) ? 5'd0 : 5'($urandom());
            rd_cycle(f, got);
            stat_m = stat_m | f;
            chk(f == 0 ? "R10 clean read" : (ctrl_m[6] ? "R8 bus error" : "R9 data invalid"),
                {29'b0, got}, {29'b0, exp_resp(ctrl_m[6], f)});
        end
        host(1'b0, 4'd1, '0, rd, fs);
        chk("R7 status sticky", rd, {27'b0, stat_m});

        // R7: write-one-to-clear on part of the status
        host(1'b1, 4'd1, 32'h5, rd, fs);
        stat_m = stat_m & ~5'h5;
        host(1'b0, 4'd1, '0, rd, fs);
        chk("R7 status w1c", rd, {27'b0, stat_m});
        rd_cycle(5'h10, got);
        stat_m = stat_m | 5'h10;

        // R3: setting refused without EEPROM done
        host(1'b1, 4'd0, 32'h20, rd, fs);
        #1 chk("R3 no set without eeprom", {31'b0, pci_srst}, 32'd0);
        host(1'b0, 4'd0, '0, rd, fs);
        chk("R3 bit stays clear", rd & 32'h20, 32'd0);

        // R3/R5/R6: enter soft reset with all enables requested
        eeprom_done = 1'b1;
        host(1'b1, 4'd0, 32'h7E0, rd, fs);
        chk("R3 pci_srst next cycle", {31'b0, pci_srst}, 32'd1);
        chk("R3 reload not yet", {31'b0, cfg_reload}, 32'd0);
        @(posedge clk); #1;
        chk("R3 cfg_reload", {31'b0, cfg_reload}, 32'd1);
        chk("R6 enables at default", {28'b0, mem_en, io_en}, 32'h8);
        host(1'b0, 4'd0, '0, rd, fs);
        chk("R6 ctrl during reset", rd, dflt_ctrl(1'b1) | 32'h20);
        host(1'b0, 4'd1, '0, rd, fs);
        chk("R5 status read refused", rd, 32'd0);
        host(1'b1, 4'd1, 32'h1F, rd, fs);
        host(1'b0, 4'd6, '0, rd, fs);
        chk("R5 forward read refused", rd, 32'd0);
        host(1'b1, 4'd6, 32'h1234, rd, fs);
        chk("R5 no forward req", {31'b0, fs}, 32'd0);

        // R4: clear early, reset held until tick count is reached
        tick(); tick();
        host(1'b1, 4'd0, 32'h780, rd, fs);
        repeat (3) @(posedge clk);
        #1 chk("R4 held after early clear", {31'b0, pci_srst}, 32'd1);
        tick(); tick();
        repeat (2) @(posedge clk);
        #1 chk("R4 released after ticks", {31'b0, pci_srst}, 32'd0);
        chk("R4 reload released", {31'b0, cfg_reload}, 32'd0);
        host(1'b0, 4'd0, '0, rd, fs);
        chk("R6 write during reset ignored", rd, dflt_ctrl(1'b1));
        host(1'b0, 4'd1, '0, rd, fs);
        chk("R7 status kept over soft reset", rd, {27'b0, stat_m});

        // R4: clear late, release one cycle after the clearing write
        host(1'b1, 4'd0, 32'h20, rd, fs);
        repeat (6) tick();
        host(1'b1, 4'd0, 32'h0, rd, fs);
        chk("R4 still high at clear", {31'b0, pci_srst}, 32'd1);
        @(posedge clk); #1;
        chk("R4 drop one cycle after clear", {31'b0, pci_srst}, 32'd0);

        // R1: hardware reset with normal boot
        hw_reset(1'b0);
        host(1'b0, 4'd0, '0, rd, fs);
        chk("R1 ctrl default normal boot", rd, dflt_ctrl(1'b0));
        host(1'b0, 4'd1, '0, rd, fs);
        chk("R1 status cleared by hw reset", rd, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule